// File: doc/BRIEF.md
# Rate Selectable Transmit Serializer

This block turns 10-bit transmit characters into a serial bit stream. The characters arrive on a parallel bus together with a byte clock whose frequency never changes. A rate-select input sets the character rate. In the lower mode, one character is taken on each falling edge of the byte clock. In the higher mode, one character is taken on every edge of the byte clock, rising and falling. The bit clock that drives the block runs at twenty times the byte clock and is phase related to it, so the byte clock is sampled directly in the bit-clock domain. At the lower rate each serial bit lasts two bit-clock cycles. At the higher rate each bit lasts one cycle.

Captured characters wait in a two-entry buffer until the serializer reaches a character boundary. A rate change is applied only at such a boundary. It is followed by one quiet character time at the new rate, and characters buffered or offered during the switch are discarded. A loopback input moves the stream onto an auxiliary output that feeds the local receiver and holds the primary output low.

Top module: `rate_tx_serializer`

## Requirements
- R1: After reset, both serial outputs stay 0 until a captured character starts.
- R2: Each character goes out bit 0 first, then bits 1 through 9 in order.
- R3: With rate_sel = 0, only a falling byte_clk edge captures a character, a rising edge is ignored, and each bit is held for 2 clk cycles.
- R4: With rate_sel = 1, both byte_clk edges capture a character, each bit lasts 1 clk cycle, and characters captured every 10 cycles leave back to back with none lost.
- R5: Bit 0 of a captured character appears in the clk cycle after the first clk edge at which the new byte_clk level is sampled.
- R6: A rate_sel change lets the character in flight finish at the old rate. Both outputs are then 0 for one character time at the new rate (10 or 20 cycles). Buffered characters and edges during that time are discarded, and later characters use the new rate.
- R7: With loopback = 1, the stream appears on aux_out and ser_out is held at 0.
- R8: With loopback = 0, the stream appears on ser_out and aux_out stays 0.
- R9: The rate_sel level present during reset is the starting rate, so no quiet switch period follows reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 20 times byte_clk |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_clk | input | 1 | Fixed-frequency transmit byte clock, sampled by clk |
| tx_char | input | 10 | Character to capture |
| rate_sel | input | 1 | 0 = lower rate (falling edge), 1 = higher rate (both edges) |
| loopback | input | 1 | 1 = stream to aux_out, ser_out held low |
| ser_out | output | 1 | Primary serial output |
| aux_out | output | 1 | Auxiliary serial output toward the receiver |

## Verification
Several corner cases are targeted, each with the failure it would expose:
- A rising edge at the lower rate carrying a different character. A design that captures on the wrong edge would transmit it.
- A rate switch made in the middle of a character. A design that switches at once would cut that character short or stretch its bits.
- A character offered during the quiet period, and one already buffered when the switch begins. A design that does not flush would send them late at the wrong rate.
- Leaving reset with rate_sel = 1 and an immediate edge. A design that always starts at the lower rate would open with a quiet period and drop that character.

// File: rtl/rts_pkg.sv
// Shared types for the rate selectable transmit serializer.
package rts_pkg;
    // Serializer engine state: idle zeros, shifting a character, quiet rate switch.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/rts_edge_capture.sv
// Detects byte-clock edges in the bit-clock domain and raises a capture strobe.
// Assumes byte_clk is phase related to clk (derived from the same source), so no
// synchronizer is used. Falling edges always capture; rising edges capture only
// when dual-edge mode is active.
module rts_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_clk,
    input  logic dual_edge,
    output logic cap
);
    logic bclk_q;

    // Track the previous byte clock level; follows the input in reset too, so no false edge on release.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_q <= byte_clk;
        else        bclk_q <= byte_clk;
    end

    // Capture strobe from the selected edge set.
    always_comb begin
        cap = (!byte_clk && bclk_q) || (dual_edge && byte_clk && !bclk_q);
    end
endmodule

// File: rtl/rts_char_fifo.sv
// Small character buffer between the capture strobe and the serializer.
// Assumes the reader pops only when not empty. A push into a full buffer without
// a pop in the same cycle is dropped. Flush empties it and wins over a push.
module rts_char_fifo #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic             empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             wr_ok;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Accept a write when space exists or a slot frees this cycle.
    always_comb begin
        wr_ok = push && ((count != CNT_FULL) || pop);
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_ok && !flush) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= ptr_inc(wr_ptr);
            if (pop)   rd_ptr <= ptr_inc(rd_ptr);
            case ({wr_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head of queue and empty flag.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (count == '0);
    end
endmodule

// File: rtl/rts_bit_engine.sv
// Serializer engine: shifts one character out LSB first, one bit per clk at the
// higher rate and one bit per SLOW_DIV clks at the lower rate. Applies a
// rate_sel change only at a character boundary, then stays quiet for one
// character time at the new rate while ordering the buffer to flush.
// Assumes SLOW_DIV >= 2.
module rts_bit_engine
    import rts_pkg::*;
#(
    parameter int CHAR_W   = 10,
    parameter int SLOW_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_sel,
    input  logic              buf_empty,
    input  logic [CHAR_W-1:0] buf_head,
    output logic              pop,
    output logic              flush,
    output logic              bit_out,
    output eng_state_t        state_o,
    output logic [$clog2(CHAR_W)-1:0] idx_o,
    output logic              rate_o
);
    localparam int IDX_W = $clog2(CHAR_W);
    localparam int SUB_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHAR_W - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SLOW_DIV - 1);

    eng_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [SUB_W-1:0]  sub;
    logic [CHAR_W-1:0] cur;
    logic              act_rate;
    logic              tick, at_end, rate_diff, start_gap;

    // Bit-slot timing and boundary decisions.
    always_comb begin
        tick      = act_rate || (sub == SUB_LAST);
        at_end    = tick && (idx == IDX_LAST);
        rate_diff = (rate_sel != act_rate);
        start_gap = rate_diff && ((state == ST_IDLE) || ((state == ST_SEND) && at_end));
        pop       = !start_gap && !buf_empty &&
                    ((state == ST_IDLE) || ((state == ST_SEND) && at_end));
        flush     = start_gap;
    end

    // Engine state, slot counters, current character and active rate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            sub      <= '0;
            cur      <= '0;
            act_rate <= rate_sel;
        end else if (start_gap) begin
            state    <= ST_GAP;
            act_rate <= rate_sel;
            idx      <= '0;
            sub      <= '0;
        end else if (pop) begin
            state <= ST_SEND;
            cur   <= buf_head;
            idx   <= '0;
            sub   <= '0;
        end else if (state != ST_IDLE) begin
            if (at_end) begin
                state <= ST_IDLE;
                idx   <= '0;
                sub   <= '0;
            end else if (tick) begin
                idx <= idx + 1'b1;
                sub <= '0;
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end

    // Serial bit and observation outputs.
    always_comb begin
        bit_out = (state == ST_SEND) && cur[idx];
        state_o = state;
        idx_o   = idx;
        rate_o  = act_rate;
    end
endmodule

// File: rtl/rate_tx_serializer.sv
// Top of the rate selectable transmit serializer. Captures characters from the
// parallel bus on the byte-clock edges chosen by the active rate, buffers them,
// serializes them LSB first and steers the stream to the primary or auxiliary
// output. Assumes clk runs at 20x byte_clk and is phase related to it.
module rate_tx_serializer
    import rts_pkg::*;
#(
    parameter int CHAR_W    = 10,
    parameter int BUF_DEPTH = 2,
    parameter int SLOW_DIV  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_clk,
    input  logic [CHAR_W-1:0] tx_char,
    input  logic              rate_sel,
    input  logic              loopback,
    output logic              ser_out,
    output logic              aux_out
);
    localparam int IDX_W = $clog2(CHAR_W);

    logic              cap, push, pop, flush, buf_empty, bit_out;
    logic [CHAR_W-1:0] buf_head;
    eng_state_t        eng_state;
    logic [IDX_W-1:0]  eng_idx;
    logic              eng_rate;

    rts_edge_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_clk  (byte_clk),
        .dual_edge (eng_rate),
        .cap       (cap)
    );

    // Captures are refused while a rate switch is in its quiet period.
    always_comb begin
        push = cap && (eng_state != ST_GAP);
    end

    rts_char_fifo #(.WIDTH(CHAR_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (tx_char),
        .pop   (pop),
        .flush (flush),
        .dout  (buf_head),
        .empty (buf_empty)
    );

    rts_bit_engine #(.CHAR_W(CHAR_W), .SLOW_DIV(SLOW_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate_sel  (rate_sel),
        .buf_empty (buf_empty),
        .buf_head  (buf_head),
        .pop       (pop),
        .flush     (flush),
        .bit_out   (bit_out),
        .state_o   (eng_state),
        .idx_o     (eng_idx),
        .rate_o    (eng_rate)
    );

    // Output steering: loopback sends the stream to aux and parks the primary low.
    always_comb begin
        ser_out = loopback ? 1'b0 : bit_out;
        aux_out = loopback ? bit_out : 1'b0;
    end
endmodule

// File: rtl/rate_tx_serializer_chk.sv
// Property checker for rate_tx_serializer, attached by bind below.
module rate_tx_serializer_chk
    import rts_pkg::*;
#(
    parameter int CHAR_W = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      loopback,
    input logic                      ser_out,
    input logic                      aux_out,
    input eng_state_t                eng_state,
    input logic [$clog2(CHAR_W)-1:0] eng_idx,
    input logic                      eng_rate,
    input logic                      buf_empty
);
    localparam logic [$clog2(CHAR_W)-1:0] LAST = $clog2(CHAR_W)'(CHAR_W - 1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_IDLE) |-> (!ser_out && !aux_out));

    // R6
    gap_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_state == ST_GAP) |-> buf_empty);

    // R6
    rate_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(eng_rate) |-> (($past(eng_state) != ST_SEND) || ($past(eng_idx) == LAST)));

    // R7
    lb_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && $past(loopback)) |-> $stable(ser_out));

    // R8
    one_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_out && aux_out));
endmodule

bind rate_tx_serializer rate_tx_serializer_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .loopback  (loopback),
    .ser_out   (ser_out),
    .aux_out   (aux_out),
    .eng_state (eng_state),
    .eng_idx   (eng_idx),
    .eng_rate  (eng_rate),
    .buf_empty (buf_empty)
);

// File: tb/sim_rate_tx_serializer.sv
module sim_rate_tx_serializer;
    localparam int W    = 10;
    localparam int NBUF = 4096;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         byte_clk = 1'b0;
    logic [W-1:0] tx_char = '0;
    logic         rate_sel = 1'b0;
    logic         loopback = 1'b0;
    logic         ser_out, aux_out;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic sbuf [NBUF];
    logic abuf [NBUF];

    rate_tx_serializer u0 (
        .clk(clk), .rst_n(rst_n), .byte_clk(byte_clk), .tx_char(tx_char),
        .rate_sel(rate_sel), .loopback(loopback), .ser_out(ser_out), .aux_out(aux_out)
    );

    always #5 clk = ~clk;

    // Edge index: after posedge n, cyc == n.
    always @(posedge clk) cyc <= cyc + 1;

    // Record outputs away from the active edge.
    always @(negedge clk) begin
        if (cyc < NBUF) begin
            sbuf[cyc] = ser_out;
            abuf[cyc] = aux_out;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Present a character and flip byte_clk; p0 is the edge at which it is sampled.
    task automatic edge_with(input logic [W-1:0] ch, output int p0);
        tx_char  = ch;
        byte_clk = ~byte_clk;
        p0       = cyc + 1;
    endtask

    // Expect character ch starting the cycle after p0, m cycles per bit.
    task automatic check_char(input int p0, input logic [W-1:0] ch, input int m,
                              input bit on_aux, input string req);
        int bad = 0;
        int first_act = 0, first_exp = 0;
        for (int k = 0; k < W; k++) begin
            for (int s = 0; s < m; s++) begin
                int c = p0 + 1 + k * m + s;
                logic a = on_aux ? abuf[c] : sbuf[c];
                logic o = on_aux ? sbuf[c] : abuf[c];
                if (a !== ch[k] || o !== 1'b0) begin
                    if (bad == 0) begin
                        first_act = {o, a};
                        first_exp = {1'b0, ch[k]};
                    end
                    bad++;
                end
            end
        end
        check(bad == 0, req, $sformatf("char %h bits (other,data) first mismatch", ch),
              first_act, first_exp);
    endtask

    task automatic check_quiet(input int from, input int to, input string req);
        int bad = 0;
        for (int c = from; c <= to; c++)
            if (sbuf[c] !== 1'b0 || abuf[c] !== 1'b0) bad++;
        check(bad == 0, req, $sformatf("nonzero samples in cycles %0d..%0d", from, to), bad, 0);
    endtask

    // R1: idle zeros after reset.
    task automatic t_reset();
        int r0;
        rst_n = 1'b0; rate_sel = 1'b0; loopback = 1'b0; byte_clk = 1'b0;
        step(4);
        rst_n = 1'b1;
        r0 = cyc;
        step(30);
        check_quiet(r0 - 2, r0 + 29, "R1");
    endtask

    // R2, R3, R5: lower rate, rising edges ignored, bits doubled.
    task automatic t_half();
        int pa, pb, pc, pd;
        edge_with(10'h2C5, pa); step(10);   // rise: ignored
        edge_with(10'h0B3, pb); step(10);   // fall: captured
        edge_with(10'h3FF, pc); step(10);   // rise: ignored
        edge_with(10'h1A6, pd); step(30);   // fall: captured
        check_quiet(pa, pb, "R3");
        check_char(pb, 10'h0B3, 2, 1'b0, "R2");
        check_char(pd, 10'h1A6, 2, 1'b0, "R3");
        check_quiet(pd + 21, pd + 28, "R3");
        check(pc == pb + 10, "R5", "edge spacing", pc - pb, 10);
    endtask

    // R6: switch to the higher rate while idle; edge in the quiet time is dropped.
    task automatic t_rate_idle();
        int q, pe;
        rate_sel = 1'b1;
        q = cyc + 1;
        step(3);
        edge_with(10'h155, pe); step(40);
        check_quiet(q, q + 38, "R6");
        check(pe == q + 3, "R6", "edge in quiet period", pe - q, 3);
    endtask

    // R4, R5: higher rate stream on both edges, back to back.
    task automatic t_full();
        logic [W-1:0] chs [6];
        int p [6];
        chs[0] = 10'h001; chs[1] = 10'h200; chs[2] = 10'h2AA;
        chs[3] = 10'h155; chs[4] = 10'h3C3; chs[5] = 10'h0F1;
        for (int j = 0; j < 6; j++) begin
            edge_with(chs[j], p[j]);
            step(10);
        end
        step(15);
        for (int j = 0; j < 6; j++) check_char(p[j], chs[j], 1, 1'b0, "R4");
        check_quiet(p[5] + 11, p[5] + 20, "R4");
        check(p[1] == p[0] + 10, "R5", "first character latency base", p[1] - p[0], 10);
    endtask

    // R7, R8: loopback steering.
    task automatic t_loop();
        int pl, pm;
        loopback = 1'b1; step(2);
        edge_with(10'h2D9, pl); step(15);
        check_char(pl, 10'h2D9, 1, 1'b1, "R7");
        loopback = 1'b0; step(2);
        edge_with(10'h1B7, pm); step(15);
        check_char(pm, 10'h1B7, 1, 1'b0, "R8");
    endtask

    // R6: switch to the lower rate mid-character; buffered character flushed.
    task automatic t_rate_mid();
        int pg, ph, px, pi;
        edge_with(10'h36D, pg); step(3);
        rate_sel = 1'b0;                     // sampled at edge pg+3
        step(6);
        edge_with(10'h3FE, ph); step(50);    // captured at old rate, then flushed
        check_char(pg, 10'h36D, 1, 1'b0, "R6");
        check_quiet(pg + 11, pg + 55, "R6");
        if (byte_clk == 1'b0) begin
            edge_with(10'h3FF, px); step(10);  // rise, ignored at lower rate
        end
        edge_with(10'h0CA, pi); step(25);
        check_char(pi, 10'h0CA, 2, 1'b0, "R6");
        check(ph == pg + 9, "R6", "flushed capture edge", ph - pg, 9);
    endtask

    // R9: reset at the higher rate starts with no quiet period.
    task automatic t_reset_full();
        int pr, pr2;
        rst_n = 1'b0; rate_sel = 1'b1;
        step(3);
        rst_n = 1'b1;
        edge_with(10'h2B1, pr); step(10);
        edge_with(10'h14E, pr2); step(15);
        check_char(pr, 10'h2B1, 1, 1'b0, "R9");
        check_char(pr2, 10'h14E, 1, 1'b0, "R9");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1;
        t_reset();
        t_half();
        t_rate_idle();
        t_full();
        t_loop();
        t_rate_mid();
        t_reset_full();
        finish_run();
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end
endmodule